// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link made of a bit clock, a word clock and a data line. It returns a left sample and a right sample, each with a one-cycle valid strobe. Everything runs in the bit-clock domain. The word clock is sampled on every rising bit-clock edge and compared with its previous sample to find channel boundaries. Data bits are shifted in MSB first.

A run-time format select chooses one of three framings, and a word-length select chooses 16, 20, 24 or 32 bits per sample. The framings are:

- Right-aligned: the word ends at the channel boundary.
- One-bit-delayed: the word starts one bit after the boundary.
- Pulse-framed: a short word-clock pulse starts a frame, and the two words follow back to back.

Samples come out MSB-aligned in 32 bits. A new format or word length is applied only at a frame start. Until the first frame start after reset, the block produces no output.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_n` is low, `left_data`, `right_data`, `left_vld` and `right_vld` are all zero. Reset is asynchronous, so they clear at once.
- R2: Format code 0 (code 3 behaves the same) is right-aligned. The word clock is high for the left slot and low for the right slot. The last N bits captured before a word-clock change form the word of the slot that just ended. Extra leading bits in a longer slot are discarded.
- R3: Format code 1 is one-bit-delayed. The word clock is low for the left slot and high for the right slot. The first edge that sees a word-clock change still carries the previous word's last bit. The MSB of the new word is captured on the next edge, and bits after the N-th are ignored.
- R4: Format code 2 is pulse-framed. A rising word clock marks the frame start. The left word's MSB is captured on the edge after the one that saw the rise. The right word follows with no gap. Bits after the right word, up to the next frame start, are ignored.
- R5: Word-length code 0 selects 16 bits, 1 selects 20, 2 selects 24 and 3 selects 32. Each sample sits in bits 31 down to 32-N, and all lower bits are zero.
- R6: Serial data is sent MSB first in every format, and all bits are captured on rising bit-clock edges.
- R7: Each completed word gives exactly one one-cycle pulse on its channel's valid output. The data output updates in the same cycle. The left and right strobes are never high together.
- R8: A change of `fmt` or `wlen` takes effect only at the next frame start: a word-clock rise in codes 0, 2 and 3, a fall in code 1. A word that completes on a frame-start edge still uses the old setting.
- R9: After reset, no sample is delivered until a frame start has been seen, so a partial first frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Word/frame clock |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing: 0 right-aligned, 1 one-bit-delayed, 2 pulse-framed, 3 as 0 |
| wlen | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| left_data | output | 32 | Last left sample, MSB-aligned |
| left_vld | output | 1 | One-cycle pulse when a left sample is delivered |
| right_data | output | 32 | Last right sample, MSB-aligned |
| right_vld | output | 1 | One-cycle pulse when a right sample is delivered |

## Verification
Every format is driven with each of its slot layouts at several word lengths, using 32-bit slots. Padding bits are sent as ones, and many samples have a zero MSB. A window that slides by one bit therefore changes the received value, which separates right-aligned capture, the one-bit delay and the back-to-back pulse-framed words. The 32-bit cases put the delayed LSB on the boundary edge itself. A word-length change partway through a frame shows whether the old setting is kept until the next frame start. A reset released inside a slot shows whether a partial frame leaks out.

// File: rtl/audio_serial_rx.sv
module audio_serial_rx (
  input  logic        bclk,
  input  logic        rst_n,
  input  logic        wclk,
  input  logic        sdata,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wlen,
  output logic [31:0] left_data,
  output logic        left_vld,
  output logic [31:0] right_data,
  output logic        right_vld
);
  localparam int SW = 32;
  localparam logic [6:0] SWV = 7'(SW);
  localparam logic [1:0] FMT_DLY = 2'd1;
  localparam logic [1:0] FMT_PLS = 2'd2;

  logic          wclk_q, seen, armed;
  logic [1:0]    cfg_fmt, cfg_wlen;
  logic [SW-1:0] sr, word, aligned, lsb_mask;
  logic [6:0]    cnt, nbits, limit;
  logic          toggle, rise, is_dly, is_pls, is_rj, fstart, cnt_clr, last_n;
  logic          done_l, done_r;

  assign toggle  = seen && (wclk != wclk_q);
  assign rise    = toggle && wclk;
  assign is_dly  = cfg_fmt == FMT_DLY;
  assign is_pls  = cfg_fmt == FMT_PLS;
  assign is_rj   = !is_dly && !is_pls;
  assign fstart  = is_dly ? (toggle && !wclk) : rise;
  assign cnt_clr = is_dly ? toggle : rise;
  assign nbits   = (cfg_wlen == 2'd3) ? 7'd32 : 7'd16 + {3'd0, cfg_wlen, 2'd0};
  assign limit   = is_pls ? {nbits[5:0], 1'b0} : (is_dly ? nbits : 7'd0);
  assign last_n  = cnt == nbits - 7'd1;

  assign done_l = is_rj ? (toggle && wclk_q)  : is_dly ? (last_n && !wclk_q) : last_n;
  assign done_r = is_rj ? (toggle && !wclk_q) : is_dly ? (last_n && wclk_q)
                                                       : (cnt == limit - 7'd1);

  assign word     = is_rj ? sr : {sr[SW-2:0], sdata};
  assign aligned  = word << (SWV - nbits);
  assign lsb_mask = ~({SW{1'b1}} << (SWV - nbits));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q     <= 1'b0;
      seen       <= 1'b0;
      armed      <= 1'b0;
      cfg_fmt    <= 2'd0;
      cfg_wlen   <= 2'd0;
      sr         <= '0;
      cnt        <= '0;
      left_data  <= '0;
      right_data <= '0;
      left_vld   <= 1'b0;
      right_vld  <= 1'b0;
    end else begin
      wclk_q <= wclk;
      seen   <= 1'b1;
      sr     <= {sr[SW-2:0], sdata};
      if (!armed || fstart) begin
        cfg_fmt  <= fmt;
        cfg_wlen <= wlen;
      end
      if (fstart) armed <= 1'b1;
      if (cnt_clr || fstart) cnt <= '0;
      else if (cnt < limit)  cnt <= cnt + 7'd1;
      left_vld  <= armed && done_l;
      right_vld <= armed && done_r;
      if (armed && done_l) left_data  <= aligned;
      if (armed && done_r) right_data <= aligned;
    end
  end

  a_r7_one_side: assert property (@(posedge bclk) disable iff (!rst_n)
    !(left_vld && right_vld));

  a_r7_single_pulse: assert property (@(posedge bclk) disable iff (!rst_n)
    left_vld |=> !left_vld);

  a_r2_rj_left_at_fall: assert property (@(posedge bclk) disable iff (!rst_n)
    (left_vld && $past(is_rj)) |-> ($past(wclk_q) && !wclk_q));

  a_r5_left_zero_fill: assert property (@(posedge bclk) disable iff (!rst_n)
    left_vld |-> ((left_data & $past(lsb_mask)) == '0));

  a_r5_right_zero_fill: assert property (@(posedge bclk) disable iff (!rst_n)
    right_vld |-> ((right_data & $past(lsb_mask)) == '0));
endmodule

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  logic bclk = 1'b0, rst_n = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [1:0] fmt = 2'd0, wlen = 2'd0;
  logic [31:0] left_data, right_data;
  logic left_vld, right_vld;
  int n_chk = 0, n_bad = 0, lc = 0, rc = 0;
  logic [31:0] lh [0:7];
  logic [31:0] rh [0:7];
  bit done = 1'b0;

  audio_serial_rx uut (.bclk(bclk), .rst_n(rst_n), .wclk(wclk), .sdata(sdata),
    .fmt(fmt), .wlen(wlen), .left_data(left_data), .left_vld(left_vld),
    .right_data(right_data), .right_vld(right_vld));

  always #5 bclk = ~bclk;

  // format, word length, left, right
  localparam logic [67:0] VEC [0:9] = '{
    {2'd0, 2'd0, 32'h1234_5678, 32'h8765_4321},
    {2'd0, 2'd1, 32'hA5A5_A5A5, 32'h0F0F_0F0F},
    {2'd0, 2'd2, 32'h6B3C_D201, 32'h3141_5926},
    {2'd3, 2'd3, 32'h0123_4567, 32'hFEDC_BA98},
    {2'd1, 2'd0, 32'h4000_0001, 32'hC3A5_0000},
    {2'd1, 2'd2, 32'h3355_77AA, 32'h0A0B_0C0D},
    {2'd1, 2'd3, 32'h8000_0001, 32'h7FFF_FFFE},
    {2'd2, 2'd0, 32'h5A5A_0000, 32'h2468_ACE0},
    {2'd2, 2'd1, 32'h1357_9BDF, 32'h7654_3210},
    {2'd2, 2'd3, 32'h0000_0003, 32'hC000_0000}};

  always @(negedge bclk) begin
    if (left_vld)  begin if (lc < 8) lh[lc] = left_data;  lc++; end
    if (right_vld) begin if (rc < 8) rh[rc] = right_data; rc++; end
  end

  function automatic int nb(input logic [1:0] w);
    return (w == 2'd3) ? 32 : 16 + 4 * int'(w);
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] v, input int n);
    return v & (32'hFFFF_FFFF << (32 - n));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tx(input logic wc, input logic d);
    @(negedge bclk);
    wclk = wc;
    sdata = d;
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] w, input logic wc);
    rst_n = 1'b0;
    #1;
    chk("R1 left_data", left_data, 32'h0);
    chk("R1 right_data", right_data, 32'h0);
    chk("R1 strobes", {30'd0, left_vld, right_vld}, 32'h0);
    fmt = f; wlen = w; wclk = wc; sdata = 1'b0;
    repeat (3) @(negedge bclk);
    lc = 0; rc = 0;
    rst_n = 1'b1;
  endtask

  task automatic frame(input logic [1:0] f, input int n, input logic [31:0] l,
                       input logic [31:0] r, input int sw, input logic [1:0] swv);
    int len;
    len = (f == 2'd2) ? 72 : 64;
    for (int p = 0; p < len; p++) begin
      logic wc, d;
      int q;
      logic [31:0] w;
      if (p == sw) wlen = swv;
      q = p % 32;
      w = (p < 32) ? l : r;
      d = 1'b1;
      if (f == 2'd2) begin
        wc = (p == 0);
        if (p >= 1 && p <= n) d = l[32 - p];
        else if (p > n && p <= 2 * n) d = r[32 - (p - n)];
      end else if (f == 2'd1) begin
        wc = (p >= 32);
        if (q == 0) d = (p < 32) ? r[32 - n] : l[32 - n];
        else if (q <= n) d = w[32 - q];
      end else begin
        wc = (p < 32);
        if (q >= 32 - n) d = w[31 - (q - (32 - n))];
      end
      tx(wc, d);
    end
  endtask

  task automatic tail(input logic [1:0] f, input int n, input logic [31:0] r);
    for (int p = 0; p < 4; p++) begin
      if (f == 2'd1) tx(1'b0, (p == 0) ? r[32 - n] : 1'b1);
      else if (f == 2'd2) tx(p == 0, 1'b1);
      else tx(1'b1, 1'b1);
    end
    repeat (4) tx(wclk, 1'b0);
  endtask

  initial begin
    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 10; i++) begin
      logic [1:0] f, w;
      logic [31:0] l, r;
      int n;
      {f, w, l, r} = VEC[i];
      n = nb(w);
      do_reset(f, w, f == 2'd1);
      repeat (4) tx(f == 2'd1, 1'b0);
      repeat (3) frame(f, n, l, r, -1, 2'd0);
      tail(f, n, r);
      #3;
      chk(f == 2'd1 ? "R3 left word" : f == 2'd2 ? "R4 left word" : "R2 left word",
          left_data, msk(l, n));
      chk(f == 2'd1 ? "R3 right word" : f == 2'd2 ? "R4 right word" : "R2 right word",
          right_data, msk(r, n));
      chk("R7 left pulses", lc, 32'd3);
      chk("R7 right pulses", rc, 32'd3);
    end

    // R9: reset released inside a left slot, partial frame dropped
    do_reset(2'd0, 2'd3, 1'b1);
    repeat (10) tx(1'b1, 1'b1);
    repeat (32) tx(1'b0, 1'b0);
    #3;
    chk("R9 no left before frame start", lc, 32'd0);
    chk("R9 no right before frame start", rc, 32'd0);
    frame(2'd0, 32, 32'hDEAD_BEEF, 32'h0BAD_F00D, -1, 2'd0);
    tail(2'd0, 32, 32'h0BAD_F00D);
    #3;
    chk("R9 left pulses", lc, 32'd1);
    chk("R9 right pulses", rc, 32'd1);
    chk("R9 left word", left_data, 32'hDEAD_BEEF);
    chk("R9 right word", right_data, 32'h0BAD_F00D);

    // R8: word length changed inside a frame applies at next frame start
    do_reset(2'd0, 2'd2, 1'b0);
    repeat (4) tx(1'b0, 1'b0);
    frame(2'd0, 24, 32'h9ABC_DEF1, 32'h1122_3344, -1, 2'd0);
    frame(2'd0, 24, 32'h9ABC_DEF1, 32'h1122_3344, 5, 2'd0);
    frame(2'd0, 16, 32'h7E57_0000, 32'h00C4_0000, -1, 2'd0);
    tail(2'd0, 16, 32'h00C4_0000);
    #3;
    chk("R8 left count", lc, 32'd3);
    chk("R8 right count", rc, 32'd3);
    chk("R8 left kept old length", lh[1], 32'h9ABC_DE00);
    chk("R8 right kept old length", rh[1], 32'h1122_3300);
    chk("R8 left new length", lh[2], 32'h7E57_0000);
    chk("R8 right new length", rh[2], 32'h00C4_0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule